// File: doc/BRIEF.md
# Gatable One-Shot and Square-Wave Timer

A clocked timer that replaces an RC-timed multivibrator. A loadable count `half_cnt` (N) takes the place of the timing components. Every programmed interval lasts N+1 clock cycles.

**Astable mode.** While the astable mode is enabled, the block runs free. It drives a square wave on `q` and its inverse on `q_n`. A second output, `osc_tap`, runs at twice the frequency of `q`.

**Monostable mode.** While the astable mode is disabled, the block acts as a one-shot. Two trigger inputs of opposite sense each qualify the other, so a pulse can start on either a rising or a falling edge. A retrigger input lets a fresh leading edge restart a pulse that is still running.

**Master reset.** The master reset input `mreset` pulls the output low at once and ends any running interval.

**Synchronisers.** Every asynchronous control input passes through a synchroniser of `SYNC_STAGES` flops and then one edge-detect flop. With the default of two stages, a control change made between clock edges reaches the outputs in the third cycle.

Top module: `pt_multivib`

## Requirements
- R1: After `rst_n` is released, or after `mreset` falls, `q`=0, `q_n`=1 and `osc_tap`=0 until a new trigger or an astable enable arrives.
- R2: A rising edge on `trig_pos` while `trig_neg` is low starts a pulse. `q` rises in the third clock cycle after the input change and stays high for exactly N+1 cycles.
- R3: A falling edge on `trig_neg` while `trig_pos` is high starts a pulse with the same latency and width as in R2.
- R4: A rising edge on `trig_pos` while `trig_neg` is high starts no pulse. A falling edge on `trig_neg` while `trig_pos` is low starts no pulse.
- R5: The pulse width is N+1 cycles whatever the trigger length. This holds for a one-cycle trigger and for a trigger held longer than the pulse.
- R6: With `retrig` low, a qualifying trigger edge that arrives during a pulse is ignored, and the pulse ends on its original schedule.
- R7: With `retrig` high, a `trig_pos` rising edge during a pulse reloads the count to N. From that point the pulse continues for N+1 more cycles.
- R8: While `mreset` is high, `q` is low in the same cycle, the running pulse is discarded, and trigger edges start nothing. Releasing `mreset` does not resume the old pulse.
- R9: While `run_hi` is high, `q` goes high in the third cycle after enable. It then alternates N+1 cycles high and N+1 cycles low. The output stops two cycles after `run_hi` falls.
- R10: `run_lo_n` held low enables astable mode exactly as `run_hi` does in R9.
- R11: In astable mode `osc_tap` repeats every N+1 cycles. Within each half period of `q` it is high for the first N−⌊N/2⌋ cycles and low for the rest. Outside astable mode it is low.
- R12: `q_n` is always the inverse of `q`.
- R13: With N=0 a trigger gives a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| mreset | input | 1 | Master reset, active high |
| trig_pos | input | 1 | Rising-edge trigger; the level also qualifies `trig_neg` |
| trig_neg | input | 1 | Falling-edge trigger; the level also qualifies `trig_pos` |
| retrig | input | 1 | When high, a leading edge on `trig_pos` restarts a running pulse |
| run_hi | input | 1 | Astable enable, active high |
| run_lo_n | input | 1 | Astable enable, active low |
| half_cnt | input | CNT_W | Interval count N; each interval is N+1 cycles |
| q | output | 1 | Main output |
| q_n | output | 1 | Inverse of `q` |
| osc_tap | output | 1 | Oscillator tap at twice the frequency of `q` |

## Verification
**Control inputs.** A trigger or enable change is due at the outputs exactly three clock edges later: two synchroniser flops, then the edge flop that updates the counter state. A change on `mreset` is due on the same edge, because it gates `q` combinationally.

**Scoreboard timing.** The driver changes inputs on falling clock edges. For every following rising edge it queues one expected output triple, written out from the cycle counts above. The monitor pops one triple per rising edge, a fixed fraction of a period later. Each queue entry is therefore tied to exactly one clock edge.

**Corner cases.** Disabling the astable mode is placed on a period boundary. This makes the two trailing cycles of wave and tap predictable.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int unsigned IN_NUM  = 5;
  localparam int unsigned IX_TPOS = 0;
  localparam int unsigned IX_TNEG = 1;
  localparam int unsigned IX_RTRG = 2;
  localparam int unsigned IX_RUNH = 3;
  localparam int unsigned IX_RUNL = 4;

  // rising edge on the positive trigger, qualified by a low negative trigger
  function automatic logic pos_fire(input logic rise_p, input logic neg_lvl);
    return rise_p & ~neg_lvl;
  endfunction

  // falling edge on the negative trigger, qualified by a high positive trigger
  function automatic logic neg_fire(input logic fall_n, input logic pos_lvl);
    return fall_n & pos_lvl;
  endfunction

  function automatic logic run_enable(input logic hi, input logic lo_n);
    return hi | ~lo_n;
  endfunction

  // tap is high while the remaining count lies in the upper half of the span
  function automatic logic tap_high(input logic [31:0] cnt, input logic [31:0] span);
    return cnt > (span >> 1);
  endfunction
endpackage

// File: rtl/pt_sync_edge.sv
module pt_sync_edge #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stg[s] <= INIT;
      prev <= INIT;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/pt_oneshot.sv
module pt_oneshot #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mreset,
  input  logic             fire,
  input  logic             restart,
  input  logic [CNT_W-1:0] load,
  output logic             active,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             at_zero;

  assign at_zero = (cnt == '0);
  assign expire  = active & at_zero & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (mreset) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (fire) begin
        active <= 1'b1;
        cnt    <= load;
      end
    end else if (restart) begin
      cnt <= load;
    end else if (at_zero) begin
      active <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_mr_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> !active);
  assert_fire_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && fire && !mreset) |=> (active && cnt == $past(load)));
  assert_retrig_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && restart && !mreset) |=> (active && cnt == $past(load)));
  assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart && !at_zero && !mreset) |=> (active && cnt == $past(cnt) - 1'b1));
  assert_edge_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fire && !restart && !at_zero && !mreset) |=> active);
  assert_pulse_ends_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mreset) |=> !active);
endmodule

// File: rtl/pt_astable.sv
module pt_astable #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mreset,
  input  logic             enable,
  input  logic [CNT_W-1:0] half,
  output logic             running,
  output logic             wave,
  output logic             tap
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] span;
  logic             turn;

  assign turn = running & (cnt == '0);
  assign tap  = running & pt_pkg::tap_high(32'(cnt), 32'(span));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      wave    <= 1'b0;
      cnt     <= '0;
      span    <= '0;
    end else if (mreset || !enable) begin
      running <= 1'b0;
      wave    <= 1'b0;
      cnt     <= '0;
      span    <= '0;
    end else if (!running) begin
      running <= 1'b1;
      wave    <= 1'b1;
      cnt     <= half;
      span    <= half;
    end else if (turn) begin
      wave <= ~wave;
      cnt  <= half;
      span <= half;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_half_turn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (turn && enable && !mreset) |=> (wave != $past(wave)));
  assert_half_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !turn && enable && !mreset) |=> $stable(wave));
  assert_start_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && enable && !mreset) |=> (running && wave));
  assert_gated_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || mreset) |=> (!running && !tap));
endmodule

// File: rtl/pt_multivib.sv
module pt_multivib #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mreset,
  input  logic             trig_pos,
  input  logic             trig_neg,
  input  logic             retrig,
  input  logic             run_hi,
  input  logic             run_lo_n,
  input  logic [CNT_W-1:0] half_cnt,
  output logic             q,
  output logic             q_n,
  output logic             osc_tap
);
  import pt_pkg::*;

  localparam int unsigned NIN = IN_NUM;
  localparam logic [NIN-1:0] IDLE_LVL = NIN'(1) << IX_RUNL;

  logic [NIN-1:0] raw_in, in_lvl, in_rise, in_fall;
  logic ev_fire, ev_restart, run_en;
  logic os_active, os_expire;
  logic ast_running, ast_wave, ast_tap;
  logic mode_out;

  always_comb begin
    raw_in          = '0;
    raw_in[IX_TPOS] = trig_pos;
    raw_in[IX_TNEG] = trig_neg;
    raw_in[IX_RTRG] = retrig;
    raw_in[IX_RUNH] = run_hi;
    raw_in[IX_RUNL] = run_lo_n;
  end

  pt_sync_edge #(.W(NIN), .STAGES(SYNC_STAGES), .INIT(IDLE_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_in),
    .lvl(in_lvl), .rise(in_rise), .fall(in_fall)
  );

  assign ev_fire    = pos_fire(in_rise[IX_TPOS], in_lvl[IX_TNEG])
                    | neg_fire(in_fall[IX_TNEG], in_lvl[IX_TPOS]);
  assign ev_restart = in_rise[IX_TPOS] & in_lvl[IX_RTRG];
  assign run_en     = run_enable(in_lvl[IX_RUNH], in_lvl[IX_RUNL]);

  pt_oneshot #(.CNT_W(CNT_W)) u_oneshot (
    .clk(clk), .rst_n(rst_n), .mreset(mreset),
    .fire(ev_fire), .restart(ev_restart), .load(half_cnt),
    .active(os_active), .expire(os_expire)
  );

  pt_astable #(.CNT_W(CNT_W)) u_astable (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .enable(run_en),
    .half(half_cnt), .running(ast_running), .wave(ast_wave), .tap(ast_tap)
  );

  assign mode_out = ast_running ? ast_wave : os_active;
  assign q        = ~mreset & mode_out;
  assign q_n      = ~q;
  assign osc_tap  = ~mreset & ast_tap;

  assert_fire_drives_q_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && !os_active && !mreset && !ast_running && !run_en) |=> (q || mreset));
  assert_expire_drops_q_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (os_expire && !ast_running && !run_en) |=> !q);
endmodule

// File: tb/test_pt_multivib.sv
module test_pt_multivib;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n, mreset, trig_pos, trig_neg, retrig, run_hi, run_lo_n;
  logic [CW-1:0] half_cnt;
  logic q, q_n, osc_tap;

  typedef struct { logic eq; logic et; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pt_multivib #(.CNT_W(CW), .SYNC_STAGES(2)) i_pt_multivib (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .trig_pos(trig_pos),
    .trig_neg(trig_neg), .retrig(retrig), .run_hi(run_hi), .run_lo_n(run_lo_n),
    .half_cnt(half_cnt), .q(q), .q_n(q_n), .osc_tap(osc_tap)
  );

  // queue one expectation per upcoming rising edge
  task automatic push(input logic eq, input logic et, input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      sb.push_back('{eq, et, tag});
      @(negedge clk);
    end
  endtask

  // monitor: sample away from the edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks += 3;
      if (q !== e.eq) begin
        fails++;
        $display("FAIL %s q got %b exp %b at %0t", e.tag, q, e.eq, $time);
      end
      if (q_n !== ~e.eq) begin
        fails++;
        $display("FAIL R12 q_n got %b exp %b at %0t", q_n, ~e.eq, $time);
      end
      if (osc_tap !== e.et) begin
        fails++;
        $display("FAIL R11/%s osc_tap got %b exp %b at %0t", e.tag, osc_tap, e.et, $time);
      end
    end
  end

  // astable run: n >= 1, three full periods, disable on a period boundary
  task automatic astable(input int n, input bit use_lo, input string tag);
    half_cnt = CW'(n);
    if (use_lo) run_lo_n = 1'b0; else run_hi = 1'b1;
    push(0, 0, tag, 2);
    for (int p = 0; p < 3; p++)
      for (int ph = 0; ph < 2; ph++)
        for (int i = 0; i <= n; i++)
          push(ph == 0, (n - i) > (n / 2), tag, 1);
    if (use_lo) run_lo_n = 1'b1; else run_hi = 1'b0;
    for (int i = 0; i < 2; i++) push(1, (n - i) > (n / 2), tag, 1);
    push(0, 0, tag, 4);
  endtask

  initial begin
    rst_n = 0; mreset = 0; trig_pos = 0; trig_neg = 0; retrig = 0;
    run_hi = 0; run_lo_n = 1; half_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    push(0, 0, "R1", 3);

    // R13: N=0, one-cycle trigger
    half_cnt = 0; trig_pos = 1; push(0, 0, "R13", 1);
    trig_pos = 0; push(0, 0, "R13", 1); push(1, 0, "R13", 1); push(0, 0, "R13", 4);

    // R2 / R5: N=4, short trigger
    half_cnt = 4; trig_pos = 1; push(0, 0, "R2", 1);
    trig_pos = 0; push(0, 0, "R2", 1); push(1, 0, "R2", 5); push(0, 0, "R2", 3);

    // R5: N=2, trigger far longer than the pulse
    half_cnt = 2; trig_pos = 1; push(0, 0, "R5", 2); push(1, 0, "R5", 3); push(0, 0, "R5", 6);
    trig_pos = 0; push(0, 0, "R5", 3);

    // R6: second edge during pulse ignored, N=5
    half_cnt = 5; trig_pos = 1; push(0, 0, "R6", 2); push(1, 0, "R6", 2);
    trig_pos = 0; push(1, 0, "R6", 1);
    trig_pos = 1; push(1, 0, "R6", 3); push(0, 0, "R6", 4);
    trig_pos = 0; push(0, 0, "R6", 3);

    // R7: retrigger extends, N=5
    retrig = 1; trig_pos = 1; push(0, 0, "R7", 2); push(1, 0, "R7", 2);
    trig_pos = 0; push(1, 0, "R7", 1);
    trig_pos = 1; push(1, 0, "R7", 8);
    trig_pos = 0; retrig = 0; push(0, 0, "R7", 4);

    // R3 / R4: negative-edge trigger and blocked edges, N=3
    half_cnt = 3; trig_neg = 1; push(0, 0, "R4", 4);
    trig_pos = 1; push(0, 0, "R4", 4);
    trig_neg = 0; push(0, 0, "R3", 2); push(1, 0, "R3", 4); push(0, 0, "R3", 3);
    trig_pos = 0; push(0, 0, "R4", 3);
    trig_neg = 1; push(0, 0, "R4", 4);
    trig_neg = 0; push(0, 0, "R4", 5);

    // R8: master reset truncates and blocks, N=10
    half_cnt = 10; trig_pos = 1; push(0, 0, "R8", 2); push(1, 0, "R8", 3);
    mreset = 1; push(0, 0, "R8", 1);
    trig_pos = 0; push(0, 0, "R8", 3);
    trig_pos = 1; push(0, 0, "R8", 5);
    mreset = 0; push(0, 0, "R1", 15);
    trig_pos = 0; push(0, 0, "R8", 3);

    // R9 / R10 / R11: astable via each enable
    astable(3, 0, "R9");
    astable(4, 1, "R10");
    astable(1, 0, "R9");

    wait (sb.size() == 0);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired after 200000 cycles");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule